// File: doc/BRIEF.md
# Oldest-First Crossbar Arbiter

This block decides, for every target of an asymmetric switch, which requester is served next. Eight requesters (processor cores) each present at most one request at a time. A request names one of nine targets (eight cache banks and one I/O port), says whether it is a read or a write, and says whether it belongs to the instruction side or the data side. The block captures each request, keeps its relative age, and arbitrates each target on its own. It then raises a one-cycle grant. A request presented in cycle T is captured at the end of T, arbitrated in T+1 and granted in T+2. Each step takes one clock.

When several requesters want the same target, the target serves the one whose request arrived first. Requests that arrive in the same cycle are ordered by requester index, with the lowest index first. Targets are independent, so grants to different targets go out in the same cycle. A requester that has just won a target with a write holds that target while it keeps sending writes to it, one per cycle. Each such write is granted in the following cycle, with no arbitration step. The block also keeps, per requester, a count of outstanding misses on each side and refuses new requests once a side is full.

Top module: `xbar_age_arbiter`

## Requirements
- R1: A request accepted in cycle T to an uncontested target gives a one-cycle grant pulse on `gnt` for that requester in cycle T+2. In the same cycle `tgt_gnt_v` flags the target and `tgt_gnt_src` carries the requester index. Cycle T+1 shows no grant.
- R2: Pending requests to one target are granted in the order they were captured, regardless of requester index. After a read grant the target arbitrates again in the next cycle.
- R3: Requests to one target captured in the same cycle are granted lowest requester index first.
- R4: Requests to different targets are granted in the same cycle, each on its own target.
- R5: A write grant gives the winner hold of that target. In any cycle where the holder's grant is visible, the holder may present another write to the same target. That write is granted in the next cycle, ahead of any older request waiting for the target.
- R6: Hold of a target ends at the end of any held cycle in which the holder does not present a write to that target: an idle cycle, a read, or another target. A read presented then is captured normally and granted two cycles later. Waiting requesters are arbitrated again.
- R7: Each requester may have at most 8 instruction-side (`req_kind`=0) and 8 data-side (`req_kind`=1) requests outstanding. A request whose side is full is dropped and never granted. The two sides are counted separately. A pulse on `done_i` or `done_d` frees one entry of that side.
- R8: A request is dropped, and never granted, if its requester still has a request waiting or if it names a target index of 9 or above.
- R9: After reset no grant is shown and every requester has all of its credits free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_v | input | 8 | Request present, one bit per requester |
| req_tgt | input | 32 | Target index per requester, 4 bits each (requester r at bits 4r+3..4r) |
| req_wr | input | 8 | 1 = write, 0 = read |
| req_kind | input | 8 | 0 = instruction side, 1 = data side |
| done_i | input | 8 | Completion pulse freeing one instruction-side credit |
| done_d | input | 8 | Completion pulse freeing one data-side credit |
| gnt | output | 8 | Grant pulse per requester |
| tgt_gnt_v | output | 9 | Grant issued on this target this cycle |
| tgt_gnt_src | output | 27 | Requester index granted per target, 3 bits each |

## Verification
A write continuation from a target's holder and the arbitration of an older request waiting for the same target can fall in the same cycle. The bench sets this up by parking a read from another requester on a target just after a write to it has won. The holder then sends writes back to back. The bench judges the result by cycle-exact grant order: the holder must be granted in each following cycle, and the waiting read must be granted only two cycles after the holder goes idle. A second case breaks the hold with a read from the holder itself, and the bench checks that the normal two-cycle latency returns.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    typedef enum logic {
        KIND_INSTR = 1'b0,
        KIND_DATA  = 1'b1
    } miss_kind_e;

endpackage

// File: rtl/xbar_miss_credit.sv
module xbar_miss_credit
    import xbar_arb_pkg::*;
#(
    parameter int unsigned MISS_PER_KIND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_kind,
    input  logic ret_i,
    input  logic ret_d,
    output logic ok_i,
    output logic ok_d
);
    localparam int unsigned CW = $clog2(MISS_PER_KIND + 1);
    localparam logic [CW-1:0] CMAX = CW'(MISS_PER_KIND);

    typedef struct packed {
        logic [CW-1:0] cnt_i;
        logic [CW-1:0] cnt_d;
    } cred_t;

    cred_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (take && (miss_kind_e'(take_kind) == KIND_INSTR)) c_d.cnt_i = c_d.cnt_i + 1'b1;
        if (ret_i && (c_q.cnt_i != '0))                      c_d.cnt_i = c_d.cnt_i - 1'b1;
        if (take && (miss_kind_e'(take_kind) == KIND_DATA))  c_d.cnt_d = c_d.cnt_d + 1'b1;
        if (ret_d && (c_q.cnt_d != '0))                      c_d.cnt_d = c_d.cnt_d - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ok_i = (c_q.cnt_i < CMAX);
    assign ok_d = (c_q.cnt_d < CMAX);

    // R7: outstanding count of either side never exceeds its limit
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt_i <= CMAX) && (c_q.cnt_d <= CMAX));

endmodule

// File: rtl/xbar_oldest_pick.sv
module xbar_oldest_pick #(
    parameter int unsigned N_REQ = 8
) (
    input  logic [N_REQ-1:0]         elig,
    input  logic [N_REQ*N_REQ-1:0]   older,
    output logic                     found,
    output logic [$clog2(N_REQ)-1:0] idx
);
    localparam int unsigned RW = $clog2(N_REQ);

    logic [N_REQ-1:0] cand;

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            cand[i] = elig[i];
            for (int j = 0; j < N_REQ; j++) begin
                if ((j != i) && elig[j] && !older[i*N_REQ + j]) cand[i] = 1'b0;
            end
        end
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (cand[i] && !found) begin
                found = 1'b1;
                idx   = RW'(i);
            end
        end
    end

endmodule

// File: rtl/xbar_age_arbiter.sv
module xbar_age_arbiter
    import xbar_arb_pkg::*;
#(
    parameter int unsigned N_REQ         = 8,
    parameter int unsigned N_TGT         = 9,
    parameter int unsigned MISS_PER_KIND = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_REQ-1:0]                 req_v,
    input  logic [N_REQ*$clog2(N_TGT)-1:0]   req_tgt,
    input  logic [N_REQ-1:0]                 req_wr,
    input  logic [N_REQ-1:0]                 req_kind,
    input  logic [N_REQ-1:0]                 done_i,
    input  logic [N_REQ-1:0]                 done_d,
    output logic [N_REQ-1:0]                 gnt,
    output logic [N_TGT-1:0]                 tgt_gnt_v,
    output logic [N_TGT*$clog2(N_REQ)-1:0]   tgt_gnt_src
);
    localparam int unsigned TW = $clog2(N_TGT);
    localparam int unsigned RW = $clog2(N_REQ);
    localparam logic [TW-1:0] TGT_LAST = TW'(N_TGT - 1);

    typedef struct packed {
        logic [N_REQ-1:0]       pend;
        logic [N_REQ*TW-1:0]    ptgt;
        logic [N_REQ-1:0]       pwr;
        logic [N_REQ*N_REQ-1:0] older;
        logic [N_TGT-1:0]       lock_v;
        logic [N_TGT*RW-1:0]    lock_own;
        logic [N_TGT-1:0]       gv;
        logic [N_TGT*RW-1:0]    gsrc;
    } arb_t;

    arb_t s_d, s_q;

    logic [TW-1:0]    rt     [N_REQ];
    logic [RW-1:0]    own_t  [N_TGT];
    logic [N_REQ-1:0] elig   [N_TGT];
    logic [N_REQ-1:0] kind_ok, acc_s, acc_n, ok_i, ok_d;
    logic [N_TGT-1:0] s_hit, win_v;
    logic [RW-1:0]    win_idx [N_TGT];

    // credit counters, one pair per requester
    generate
        for (genvar r = 0; r < N_REQ; r++) begin : g_cred
            xbar_miss_credit #(.MISS_PER_KIND(MISS_PER_KIND)) u_cred (
                .clk       (clk),
                .rst_n     (rst_n),
                .take      (acc_n[r] | acc_s[r]),
                .take_kind (req_kind[r]),
                .ret_i     (done_i[r]),
                .ret_d     (done_d[r]),
                .ok_i      (ok_i[r]),
                .ok_d      (ok_d[r])
            );
        end
    endgenerate

    // request decode: stream continuation, normal capture, eligibility
    always_comb begin
        for (int r = 0; r < N_REQ; r++) begin
            rt[r]      = req_tgt[r*TW +: TW];
            kind_ok[r] = req_kind[r] ? ok_d[r] : ok_i[r];
        end
        acc_s = '0;
        for (int t = 0; t < N_TGT; t++) begin
            own_t[t] = s_q.lock_own[t*RW +: RW];
            s_hit[t] = s_q.lock_v[t] && req_v[own_t[t]] && req_wr[own_t[t]]
                       && (rt[own_t[t]] == TW'(t)) && kind_ok[own_t[t]];
            if (s_hit[t]) acc_s[own_t[t]] = 1'b1;
        end
        for (int r = 0; r < N_REQ; r++) begin
            acc_n[r] = req_v[r] && !s_q.pend[r] && (rt[r] <= TGT_LAST)
                       && kind_ok[r] && !acc_s[r];
        end
        for (int t = 0; t < N_TGT; t++) begin
            for (int r = 0; r < N_REQ; r++) begin
                elig[t][r] = s_q.pend[r] && (s_q.ptgt[r*TW +: TW] == TW'(t))
                             && !s_q.lock_v[t];
            end
        end
    end

    // one oldest-first picker per target
    generate
        for (genvar t = 0; t < N_TGT; t++) begin : g_pick
            xbar_oldest_pick #(.N_REQ(N_REQ)) u_pick (
                .elig  (elig[t]),
                .older (s_q.older),
                .found (win_v[t]),
                .idx   (win_idx[t])
            );
        end
    endgenerate

    // next state
    always_comb begin
        s_d = s_q;
        for (int t = 0; t < N_TGT; t++) begin
            if (win_v[t]) s_d.pend[win_idx[t]] = 1'b0;
        end
        for (int r = 0; r < N_REQ; r++) begin
            if (acc_n[r]) begin
                s_d.pend[r]             = 1'b1;
                s_d.ptgt[r*TW +: TW]    = rt[r];
                s_d.pwr[r]              = req_wr[r];
                for (int j = 0; j < N_REQ; j++) begin
                    if (j != r) begin
                        s_d.older[r*N_REQ + j] = acc_n[j] ? (r < j) : 1'b0;
                        s_d.older[j*N_REQ + r] = acc_n[j] ? (j < r) : 1'b1;
                    end
                end
            end
        end
        for (int t = 0; t < N_TGT; t++) begin
            s_d.gv[t]              = s_hit[t] | win_v[t];
            s_d.gsrc[t*RW +: RW]   = s_hit[t] ? own_t[t] : win_idx[t];
            if (!s_hit[t]) begin
                if (win_v[t] && s_q.pwr[win_idx[t]]) begin
                    s_d.lock_v[t]              = 1'b1;
                    s_d.lock_own[t*RW +: RW]   = win_idx[t];
                end else begin
                    s_d.lock_v[t] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [N_TGT-1:0] hit_m [N_REQ];

    always_comb begin
        for (int r = 0; r < N_REQ; r++) begin
            for (int t = 0; t < N_TGT; t++) begin
                hit_m[r][t] = s_q.gv[t] && (s_q.gsrc[t*RW +: RW] == RW'(r));
            end
            gnt[r] = |hit_m[r];
        end
    end

    assign tgt_gnt_v   = s_q.gv;
    assign tgt_gnt_src = s_q.gsrc;

    generate
        for (genvar r = 0; r < N_REQ; r++) begin : g_chk_req
            // R4: a requester is granted on at most one target per cycle
            a_r4_one_target_per_req: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(hit_m[r]));
            // R1: every grant stems from a captured request or a stream write
            a_r1_grant_has_origin: assert property (@(posedge clk) disable iff (!rst_n)
                gnt[r] |-> ($past(s_q.pend[r]) || $past(acc_s[r])));
        end
        for (genvar t = 0; t < N_TGT; t++) begin : g_chk_tgt
            // R5: a held target always shows a grant to its holder
            a_r5_hold_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.lock_v[t] |-> (s_q.gv[t] && (s_q.gsrc[t*RW +: RW] == s_q.lock_own[t*RW +: RW])));
            // R6: hold ends unless the holder sent a stream write
            a_r6_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.lock_v[t] && !s_hit[t]) |=> !s_q.lock_v[t]);
        end
    endgenerate

endmodule

// File: tb/xbar_age_arbiter_test.sv
module xbar_age_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  req_v, req_wr, req_kind, done_i, done_d;
    logic [31:0] req_tgt;
    logic [7:0]  gnt;
    logic [8:0]  tgt_gnt_v;
    logic [26:0] tgt_gnt_src;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xbar_age_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_v(req_v), .req_tgt(req_tgt),
        .req_wr(req_wr), .req_kind(req_kind), .done_i(done_i), .done_d(done_d),
        .gnt(gnt), .tgt_gnt_v(tgt_gnt_v), .tgt_gnt_src(tgt_gnt_src)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_v = '0; req_wr = '0; req_kind = '0; req_tgt = '0;
        done_i = '0; done_d = '0;
    endtask

    task automatic put(input int r, input int t, input bit wr, input bit kind);
        req_v[r] = 1'b1; req_tgt[r*4 +: 4] = 4'(t); req_wr[r] = wr; req_kind[r] = kind;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 gnt after reset", gnt, 0);
        chk("R9 tgt_gnt_v after reset", tgt_gnt_v, 0);
    endtask

    task automatic t_single();
        do_reset();
        put(2, 5, 1'b0, 1'b1);
        tick(); idle();
        put(2, 7, 1'b0, 1'b1);                       // dropped: requester 2 pending (R8)
        chk("R1 no grant in arbitrate cycle", gnt, 0);
        tick(); idle();
        chk("R1 grant at T+2", gnt, 32'h04);
        chk("R1 target flag", tgt_gnt_v, 32'h020);
        chk("R1 target source", tgt_gnt_src[5*3 +: 3], 2);
        tick();
        chk("R1 grant is one cycle", gnt, 0);
        tick();
        chk("R8 request while pending dropped", gnt, 0);
        put(6, 9, 1'b0, 1'b0);                        // target 9 out of range (R8)
        tick(); idle(); tick();
        chk("R8 bad target dropped", gnt, 0);
        tick();
        chk("R8 bad target never granted", gnt, 0);
    endtask

    task automatic t_tie();
        do_reset();
        put(1, 3, 1'b0, 1'b0); put(4, 3, 1'b0, 1'b0);
        put(6, 3, 1'b0, 1'b0); put(7, 8, 1'b0, 1'b0);
        tick(); idle();
        chk("R3 arbitrate cycle quiet", gnt, 0);
        tick();
        chk("R4 two targets same cycle", gnt, 32'h82);
        chk("R4 target flags", tgt_gnt_v, 32'h108);
        tick();
        chk("R3 second lowest index next", gnt, 32'h10);
        tick();
        chk("R3 highest index last", gnt, 32'h40);
        tick();
        chk("R3 queue drained", gnt, 0);
    endtask

    task automatic t_age();
        do_reset();
        put(2, 0, 1'b0, 1'b0); put(3, 0, 1'b0, 1'b0);
        tick(); idle();
        put(0, 0, 1'b0, 1'b0);
        tick(); idle();
        chk("R2 first arrival first", gnt, 32'h04);
        tick();
        chk("R2 older beats lower index", gnt, 32'h08);
        tick();
        chk("R2 youngest last", gnt, 32'h01);
    endtask

    task automatic t_stream();
        do_reset();
        put(4, 2, 1'b1, 1'b1);
        tick(); idle();
        put(1, 2, 1'b0, 1'b1);
        tick(); idle();
        chk("R5 first write grant", gnt, 32'h10);
        put(4, 2, 1'b1, 1'b1);
        tick(); idle();
        chk("R5 stream write one cycle later", gnt, 32'h10);
        chk("R5 stream on target 2", tgt_gnt_v, 32'h004);
        put(4, 2, 1'b1, 1'b1);
        tick(); idle();
        chk("R5 stream beats older waiter", gnt, 32'h10);
        tick();
        chk("R6 idle ends hold", gnt, 0);
        tick();
        chk("R6 waiter granted after hold", gnt, 32'h02);
        chk("R6 waiter source", tgt_gnt_src[2*3 +: 3], 1);
    endtask

    task automatic t_break_read();
        do_reset();
        put(5, 6, 1'b1, 1'b1);
        tick(); idle(); tick();
        chk("R5 write wins target 6", gnt, 32'h20);
        put(5, 6, 1'b0, 1'b1);
        tick(); idle();
        chk("R6 read gets no stream grant", gnt, 0);
        tick();
        chk("R6 read granted normally", gnt, 32'h20);
        tick();
        chk("R6 no hold after read", gnt, 0);
    endtask

    task automatic t_credit();
        do_reset();
        for (int k = 0; k < 8; k++) begin
            put(3, 1, 1'b0, 1'b0);
            tick(); idle(); tick();
            chk($sformatf("R7 instr credit %0d granted", k), gnt, 32'h08);
        end
        put(3, 1, 1'b0, 1'b0);
        tick(); idle(); tick();
        chk("R7 ninth instr request dropped", gnt, 0);
        tick();
        chk("R7 ninth instr never granted", gnt, 0);
        put(3, 4, 1'b0, 1'b1);
        tick(); idle(); tick();
        chk("R7 data side independent", gnt, 32'h08);
        done_i[3] = 1'b1;
        tick(); idle();
        put(3, 1, 1'b0, 1'b0);
        tick(); idle(); tick();
        chk("R7 credit returned on done", gnt, 32'h08);
        put(3, 1, 1'b0, 1'b0);
        tick(); idle(); tick();
        chk("R7 full again after reuse", gnt, 0);
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        t_reset();
        t_single();
        t_tie();
        t_age();
        t_stream();
        t_break_read();
        t_credit();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule